// File: doc/BRIEF.md
# Dual-Channel Serial Converter Command Front-End

This block is the digital side of a two-channel 12-bit converter. It takes 16-bit command words from a three-wire serial link: an active-low select, a serial clock and a data line. It decodes each word into two 12-bit channel output registers, a power-down flag and a settling-speed flag. The analog side reads these registers directly.

The three serial inputs are asynchronous to the system clock, so each one passes through a synchronizer before any edge is detected. A frame opens when select falls. Each falling edge of the serial clock then shifts in one bit, most significant first. In self-terminating mode, the word is committed on the sixteenth falling edge and the receiver ignores all input until select rises. In externally timed mode, the word is committed when select rises, and only if exactly sixteen bits were received.

A holding register sits in front of channel B. Software can stage a channel B value there and later make it visible in the same step that writes channel A, so both channels change together.

Top module: `dacfe_dual_dac_if`

## Requirements
- R1: After reset, both channel registers and the holding register are 0, the power-down flag is 1 and the fast flag is 0.
- R2: A frame is 16 bits, sampled on falling serial clock edges while select is low, most significant bit first. Bits 11..0 carry the channel data and bits 15..12 are control bits.
- R3: With `auto_mode`=1, the word is committed after the 16th falling serial clock edge, with no rise of select needed.
- R4: With `auto_mode`=1, further clock edges after the 16th, up to the rise of select, have no effect on any output.
- R5: With `auto_mode`=0, nothing is committed until select rises. The word is committed at that rise only if exactly 16 edges were received; a frame with more edges is discarded.
- R6: A frame that ends (select rises) after fewer than 16 edges changes no register, in either mode.
- R7: A committed word with bit 15 = 1 loads channel A with the data and, in the same cycle, loads channel B from the holding register.
- R8: A committed word with bit 15 = 0 and bit 12 = 0 loads both channel B and the holding register with the data.
- R9: A committed word with bit 15 = 0 and bit 12 = 1 loads only the holding register. Channel B keeps its value.
- R10: Every committed word sets the power-down flag to the inverse of bit 13 and sets the fast flag to bit 14.
- R11: The outputs change only in the cycle after a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1: self-terminating frames; 0: select rise commits |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data |
| ch_a | output | 12 | Channel A register |
| ch_b | output | 12 | Channel B register |
| power_down | output | 1 | Power-down flag |
| fast_mode | output | 1 | Fast settling flag |

## Verification
The bound checker enforces several rules on every cycle:
- Outputs hold steady unless a commit happened in the previous cycle.
- Each commit decodes its control bits into the right register moves, and channel B picks up the holding register exactly when channel A is written.
- Once a self-terminated frame has locked, no second commit follows.
- The edge counter never passes its saturation value.

The directed scenarios cover behaviour that depends on whole frames:
- the exact commit moment in each mode;
- a short frame being discarded;
- surplus clocks in both modes;
- the staged value appearing on channel B only when channel A is written.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   localparam int CTRL_W = 4;

   // Control field as it sits in the top four bits of a frame (MSB first)
   typedef struct packed {
      logic wr_a;      // write channel A, transfer holding register to B
      logic fast;      // fast settling
      logic active;    // 0 = power-down
      logic buf_only;  // with wr_a = 0: load holding register only
   } ctrl_t;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dacfe_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= RST_VAL;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dacfe_frame_rx.sv
module dacfe_frame_rx #(
   parameter int FRAME_W = 16,
   localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               auto_mode,
   input  logic               cs_n,
   input  logic               sclk,
   input  logic               din,
   output logic               cmd_vld,
   output logic [FRAME_W-1:0] cmd_word,
   output logic               locked,
   output logic [CNT_W-1:0]   bit_cnt
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   logic               cs_d, sclk_d;
   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] shreg_nxt;
   logic               cs_fall, cs_rise, sclk_fall;

   assign cs_fall   =  cs_d & ~cs_n;
   assign cs_rise   = ~cs_d &  cs_n;
   assign sclk_fall =  sclk_d & ~sclk;
   assign shreg_nxt = {shreg[FRAME_W-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d     <= 1'b1;
         sclk_d   <= 1'b1;
         shreg    <= '0;
         bit_cnt  <= '0;
         locked   <= 1'b0;
         cmd_vld  <= 1'b0;
         cmd_word <= '0;
      end else begin
         cs_d    <= cs_n;
         sclk_d  <= sclk;
         cmd_vld <= 1'b0;
         if (cs_fall) begin
            bit_cnt <= '0;
            locked  <= 1'b0;
         end else if (cs_rise) begin
            if (!auto_mode && bit_cnt == CNT_FULL) begin
               cmd_vld  <= 1'b1;
               cmd_word <= shreg;
            end
            bit_cnt <= '0;
            locked  <= 1'b0;
         end else if (sclk_fall && !cs_n && !locked) begin
            shreg <= shreg_nxt;
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            if (auto_mode && bit_cnt == CNT_LAST) begin
               cmd_vld  <= 1'b1;
               cmd_word <= shreg_nxt;
               locked   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dacfe_reg_bank.sv
module dacfe_reg_bank
   import dacfe_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int DATA_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_vld,
   input  logic [FRAME_W-1:0] cmd_word,
   output logic [DATA_W-1:0]  ch_a,
   output logic [DATA_W-1:0]  ch_b,
   output logic [DATA_W-1:0]  dbuf,
   output logic               power_down,
   output logic               fast_mode
);

   ctrl_t             ctrl;
   logic [DATA_W-1:0] data;

   assign ctrl = ctrl_t'(cmd_word[FRAME_W-1 -: CTRL_W]);
   assign data = cmd_word[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_a       <= '0;
         ch_b       <= '0;
         dbuf       <= '0;
         power_down <= 1'b1;
         fast_mode  <= 1'b0;
      end else if (cmd_vld) begin
         power_down <= ~ctrl.active;
         fast_mode  <= ctrl.fast;
         if (ctrl.wr_a) begin
            ch_a <= data;
            ch_b <= dbuf;
         end else if (ctrl.buf_only) begin
            dbuf <= data;
         end else begin
            ch_b <= data;
            dbuf <= data;
         end
      end
   end

endmodule

// File: rtl/dacfe_dual_dac_if.sv
module dacfe_dual_dac_if
   import dacfe_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auto_mode,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   output logic [DATA_W-1:0] ch_a,
   output logic [DATA_W-1:0] ch_b,
   output logic              power_down,
   output logic              fast_mode
);

   localparam int CNT_W = $clog2(FRAME_W + 2);

   if (DATA_W + CTRL_W != FRAME_W) begin : g_bad_frame
      $error("dacfe_dual_dac_if: FRAME_W must equal DATA_W + control bits");
   end

   logic [2:0]         pins_sync;
   logic               cmd_vld;
   logic [FRAME_W-1:0] cmd_word;
   logic               rx_locked;
   logic [CNT_W-1:0]   rx_cnt;
   logic [DATA_W-1:0]  dbuf;

   dacfe_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, din}),
      .q     (pins_sync)
   );

   dacfe_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .auto_mode (auto_mode),
      .cs_n      (pins_sync[2]),
      .sclk      (pins_sync[1]),
      .din       (pins_sync[0]),
      .cmd_vld   (cmd_vld),
      .cmd_word  (cmd_word),
      .locked    (rx_locked),
      .bit_cnt   (rx_cnt)
   );

   dacfe_reg_bank #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_vld    (cmd_vld),
      .cmd_word   (cmd_word),
      .ch_a       (ch_a),
      .ch_b       (ch_b),
      .dbuf       (dbuf),
      .power_down (power_down),
      .fast_mode  (fast_mode)
   );

endmodule

// File: rtl/dacfe_dual_dac_if_chk.sv
module dacfe_dual_dac_if_chk #(
   parameter int FRAME_W = 16,
   parameter int DATA_W  = 12,
   localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_vld,
   input logic [FRAME_W-1:0] cmd_word,
   input logic               locked,
   input logic [CNT_W-1:0]   bit_cnt,
   input logic [DATA_W-1:0]  dbuf,
   input logic [DATA_W-1:0]  ch_a,
   input logic [DATA_W-1:0]  ch_b,
   input logic               power_down,
   input logic               fast_mode
);

   // R11: outputs move only after a commit
   p_hold_no_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_vld |=> ($stable(ch_a) && $stable(ch_b) && $stable(power_down) && $stable(fast_mode)));

   // R10: control flags follow the committed word
   p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> (power_down == !$past(cmd_word[FRAME_W-3]) && fast_mode == $past(cmd_word[FRAME_W-2])));

   // R7: channel A write moves the holding register into B together
   p_sync_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_word[FRAME_W-1]) |=>
         (ch_a == $past(cmd_word[DATA_W-1:0]) && ch_b == $past(dbuf)));

   // R9: staging-only write leaves B and A alone
   p_buf_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && !cmd_word[FRAME_W-1] && cmd_word[FRAME_W-4]) |=>
         ($stable(ch_b) && $stable(ch_a) && dbuf == $past(cmd_word[DATA_W-1:0])));

   // R8: direct B write also loads the holding register
   p_direct_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && !cmd_word[FRAME_W-1] && !cmd_word[FRAME_W-4]) |=>
         (ch_b == $past(cmd_word[DATA_W-1:0]) && dbuf == ch_b && $stable(ch_a)));

   // R4: a locked frame produces no further commit
   p_locked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> !cmd_vld);

   // R5: edge counter saturates instead of wrapping
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W + 1));

endmodule

bind dacfe_dual_dac_if dacfe_dual_dac_if_chk #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_vld    (cmd_vld),
   .cmd_word   (cmd_word),
   .locked     (rx_locked),
   .bit_cnt    (rx_cnt),
   .dbuf       (dbuf),
   .ch_a       (ch_a),
   .ch_b       (ch_b),
   .power_down (power_down),
   .fast_mode  (fast_mode)
);

// File: tb/dacfe_dual_dac_if_tb.sv
module dacfe_dual_dac_if_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        auto_mode = 1'b1;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic        din = 1'b0;
   logic [11:0] ch_a, ch_b;
   logic        power_down, fast_mode;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [11:0] e_a = '0, e_b = '0, e_buf = '0;
   logic        e_pd = 1'b1, e_fast = 1'b0;

   always #4 clk = ~clk;

   dacfe_dual_dac_if u_dut (
      .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
      .cs_n(cs_n), .sclk(sclk), .din(din),
      .ch_a(ch_a), .ch_b(ch_b), .power_down(power_down), .fast_mode(fast_mode)
   );

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "ch_a", 32'(ch_a), 32'(e_a));
      chk(req, "ch_b", 32'(ch_b), 32'(e_b));
      chk(req, "power_down", 32'(power_down), 32'(e_pd));
      chk(req, "fast_mode", 32'(fast_mode), 32'(e_fast));
   endtask

   // expected-register model built from the requirement text
   task automatic model(input logic [15:0] w);
      e_pd   = ~w[13];
      e_fast = w[14];
      if (w[15]) begin
         e_a = w[11:0];
         e_b = e_buf;
      end else if (w[12]) begin
         e_buf = w[11:0];
      end else begin
         e_b   = w[11:0];
         e_buf = w[11:0];
      end
   endtask

   task automatic cs_low();
      cs_n = 1'b0;
      wait_clk(4);
   endtask

   task automatic cs_high();
      cs_n = 1'b1;
      wait_clk(10);
   endtask

   task automatic shift(input logic [15:0] w, input int n);
      for (int i = 15; i > 15 - n; i--) begin
         din = w[i];
         wait_clk(4);
         sclk = 1'b0;
         wait_clk(4);
         sclk = 1'b1;
      end
      wait_clk(8);
   endtask

   task automatic t_reset();
      chk_all("R1");
   endtask

   task automatic t_auto_commit();
      auto_mode = 1'b1;
      cs_low();
      shift(16'hE5A3, 16);
      model(16'hE5A3);
      chk_all("R3");          // committed while select still low
      chk("R2", "ch_a msb-first data", 32'(ch_a), 32'h5A3);
      cs_high();
      chk_all("R3");
   endtask

   task automatic t_extra_clocks();
      auto_mode = 1'b1;
      cs_low();
      shift(16'h2123, 16);
      model(16'h2123);
      chk_all("R8");
      shift(16'hFFFF, 5);     // surplus edges while locked
      chk_all("R4");
      cs_high();
      chk_all("R4");
   endtask

   task automatic t_short();
      auto_mode = 1'b1;
      cs_low();
      shift(16'hBEEF, 10);
      cs_high();
      chk_all("R6");
      auto_mode = 1'b0;
      wait_clk(2);
      cs_low();
      shift(16'hBEEF, 15);
      cs_high();
      chk_all("R6");
      auto_mode = 1'b1;
      wait_clk(2);
   endtask

   task automatic t_double_buffer();
      auto_mode = 1'b1;
      cs_low(); shift(16'h3456, 16); cs_high();
      model(16'h3456);
      chk_all("R9");
      chk("R9", "ch_b unchanged", 32'(ch_b), 32'h123);
      cs_low(); shift(16'hA777, 16); cs_high();
      model(16'hA777);
      chk_all("R7");
      chk("R7", "ch_b from holding reg", 32'(ch_b), 32'h456);
   endtask

   task automatic t_manual();
      auto_mode = 1'b0;
      wait_clk(2);
      cs_low();
      shift(16'hC0F0, 16);
      chk_all("R5");          // nothing yet: old expectations still hold
      cs_high();
      model(16'hC0F0);
      chk_all("R5");
      chk("R10", "power_down after bit13=0", 32'(power_down), 32'h1);
      cs_low();
      shift(16'hE111, 16);
      shift(16'hFFFF, 2);     // 18 edges in total: discarded
      cs_high();
      chk_all("R5");
      auto_mode = 1'b1;
      wait_clk(2);
   endtask

   task automatic t_flags();
      auto_mode = 1'b1;
      cs_low(); shift(16'h4FFF, 16); cs_high();
      model(16'h4FFF);
      chk_all("R10");
      cs_low(); shift(16'h2001, 16); cs_high();
      model(16'h2001);
      chk_all("R10");
      chk("R10", "fast flag cleared", 32'(fast_mode), 32'h0);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      t_reset();
      t_auto_commit();
      t_extra_clocks();
      t_short();
      t_double_buffer();
      t_manual();
      t_flags();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait_clk(200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule